// File: doc/BRIEF.md
# Serial Configuration Bitstream Master

This block holds a configuration image for an SRAM-based programmable device and streams it out serially, one bit per generated configuration clock, after power-up or whenever the target is restarted. The image sits in a small internal bit store that is written one bit at a time through a plain write port. The configuration clock is derived from the system clock by a fixed even ratio. New data is presented on each falling edge of that clock, so each bit is stable at the rising edge where the target samples it.

The block is controlled by an active-high enable input and an active-low select input. The enable doubles as a reset: a low level held long enough rewinds the stream, while a shorter dip only pauses it. The select input is normally tied to the target's done flag. When it goes high, the block stops driving data and sends a fixed tail of further clocks so the target can initialise. When the block runs out of image bits, it pulls an active-low cascade output so that a following device in a chain can continue on the same clock. A one-cycle start command produces a timed low pulse on an open-drain style init output, which restarts the target.

Top module: `cfg_stream_master`

## Requirements
- R1: After `rst_n` is released, `dclk_o` stays low and `data_oe_o` stays 0 for `POR_CYCLES` system cycles. The first rising edge of `dclk_o` then follows within `CLK_DIV` cycles. This delay is applied only after `rst_n`.
- R2: Image bit 0 is presented first, followed by bits in ascending address order. The bit at address `a` is the last value written through the write port to address `a`. One bit is sampled per rising edge of `dclk_o` while `data_oe_o` is 1. `data_o` changes only at falling edges of `dclk_o` and never at a rising edge.
- R3: After the rising edge that carries the last stored bit (`IMG_BITS` bits in all), `cascade_n_o` goes to 0 and stays 0 until an accepted enable reset. From then on, `data_oe_o` is 0 and `dclk_o` keeps toggling.
- R4: While `cs_n_i` is 1, `data_oe_o` is 0 in that same cycle. From the cycle `cs_n_i` is first seen high, exactly `TAIL_CLKS` (16) further rising edges of `dclk_o` occur. After that, `dclk_o` is held low.
- R5: Holding `oe_i` low for `OE_MIN_LOW` consecutive cycles resets the block. `cascade_n_o` returns to 1, the clock stops, and streaming restarts from bit 0 without the power-on delay once `oe_i` returns high.
- R6: An `oe_i` low period shorter than `OE_MIN_LOW` cycles only pauses the block. While `oe_i` is low, `data_oe_o` is 0 and no `dclk_o` edge occurs. The stream then resumes at the same bit with no bit lost or repeated.
- R7: A high cycle on `start_cmd_i` drives `init_n_o` low for exactly `INIT_CYCLES` cycles. A start command that arrives while the pulse is running is ignored.
- R8: An image rewritten through the write port while the clock is stopped is streamed in full on the next pass after an enable reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Write strobe for the image store |
| wr_addr_i | input | $clog2(IMG_BITS) | Bit address to write |
| wr_bit_i | input | 1 | Bit value to write |
| oe_i | input | 1 | Enable; a long enough low level resets the stream |
| cs_n_i | input | 1 | Active-low select, high means the target is done |
| start_cmd_i | input | 1 | One-cycle request for a target restart pulse |
| dclk_o | output | 1 | Generated configuration clock |
| data_o | output | 1 | Serial configuration data |
| data_oe_o | output | 1 | Data pad drive enable; 0 means high impedance |
| cascade_n_o | output | 1 | Active-low enable for the next device in a chain |
| init_n_o | output | 1 | Open-drain style restart output, 0 pulls low |

## Verification
The bench captures data at every rising edge of the configuration clock and compares the bit order against a computed pattern. A design that shifted on the wrong edge or started at the wrong address would show a rotated or doubled sequence. The bench counts the tail clocks after the done flag rises, including the case where that flag rises just before a clock edge; an off-by-one tail gives 15 or 17 edges. It also inserts an enable dip one cycle shorter than the reset minimum in the middle of a stream. A design that accepted the dip as a reset would restart at bit 0, and one that kept clocking would drop bits. Finally, it retriggers the init command in the middle of a pulse, which a naive design would answer by stretching the pulse.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    typedef enum logic [2:0] {
        ST_POR  = 3'd0,
        ST_WAIT = 3'd1,
        ST_RUN  = 3'd2,
        ST_TAIL = 3'd3,
        ST_DONE = 3'd4
    } cfg_state_e;

endpackage

// File: rtl/cfg_img_store.sv
module cfg_img_store #(
    parameter int IMG_BITS = 64,
    localparam int AW = $clog2(IMG_BITS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [IMG_BITS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_bit;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_bit = mem_q[rd_addr];

endmodule

// File: rtl/cfg_clk_phase.sv
module cfg_clk_phase #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    output logic dclk,
    output logic rise,
    output logic fall
);

    localparam int HALF = DIV / 2;
    localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (clr) begin
            ph_d = '0;
        end else if (adv) begin
            ph_d = (ph_q == PW'(DIV - 1)) ? '0 : ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign dclk = (ph_q >= PW'(HALF));
    assign rise = adv && !clr && (ph_q == PW'(HALF - 1));
    assign fall = adv && !clr && (ph_q == PW'(DIV - 1));

endmodule

// File: rtl/cfg_pulse_gen.sv
module cfg_pulse_gen #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else if (trig) begin
            cnt_d = CW'(LEN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/cfg_stream_master.sv
module cfg_stream_master
    import cfg_stream_pkg::*;
#(
    parameter int IMG_BITS    = 64,
    parameter int CLK_DIV     = 4,
    parameter int TAIL_CLKS   = 16,
    parameter int POR_CYCLES  = 40,
    parameter int OE_MIN_LOW  = 3,
    parameter int INIT_CYCLES = 8,
    localparam int AW = $clog2(IMG_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic          wr_bit_i,
    input  logic          oe_i,
    input  logic          cs_n_i,
    input  logic          start_cmd_i,
    output logic          dclk_o,
    output logic          data_o,
    output logic          data_oe_o,
    output logic          cascade_n_o,
    output logic          init_n_o
);

    localparam int TW   = $clog2(TAIL_CLKS + 1);
    localparam int PORW = $clog2(POR_CYCLES + 1);
    localparam int OW   = $clog2(OE_MIN_LOW + 1);

    typedef struct packed {
        cfg_state_e      st;
        logic [AW-1:0]   addr;
        logic            exh;
        logic [TW-1:0]   tcnt;
        logic [PORW-1:0] por;
        logic [OW-1:0]   oelow;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic run_clk;
    logic accept;
    logic rise, fall;
    logic init_active;
    cfg_state_e state_w;

    assign run_clk = ((ctl_q.st == ST_RUN) || (ctl_q.st == ST_TAIL)) && oe_i;
    assign accept  = !oe_i && (ctl_q.oelow == OW'(OE_MIN_LOW - 1)) && (ctl_q.st != ST_POR);

    cfg_clk_phase #(.DIV(CLK_DIV)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (run_clk),
        .clr  (accept),
        .dclk (dclk_o),
        .rise (rise),
        .fall (fall)
    );

    cfg_img_store #(.IMG_BITS(IMG_BITS)) u_store (
        .clk    (clk),
        .wr_en  (wr_en_i),
        .wr_addr(wr_addr_i),
        .wr_bit (wr_bit_i),
        .rd_addr(ctl_q.addr),
        .rd_bit (data_o)
    );

    cfg_pulse_gen #(.LEN(INIT_CYCLES)) u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (start_cmd_i),
        .active(init_active)
    );

    always_comb begin
        ctl_d = ctl_q;

        if (!oe_i) begin
            if (ctl_q.oelow != OW'(OE_MIN_LOW)) begin
                ctl_d.oelow = ctl_q.oelow + 1'b1;
            end
        end else begin
            ctl_d.oelow = '0;
        end

        case (ctl_q.st)
            ST_POR: begin
                if (ctl_q.por == PORW'(POR_CYCLES - 1)) begin
                    ctl_d.st = ST_RUN;
                end else begin
                    ctl_d.por = ctl_q.por + 1'b1;
                end
            end
            ST_WAIT: begin
                if (oe_i) begin
                    ctl_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cs_n_i) begin
                    ctl_d.st   = ST_TAIL;
                    ctl_d.tcnt = rise ? TW'(1) : '0;
                end else if (fall && !ctl_q.exh) begin
                    if (ctl_q.addr == AW'(IMG_BITS - 1)) begin
                        ctl_d.exh = 1'b1;
                    end else begin
                        ctl_d.addr = ctl_q.addr + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (rise) begin
                    ctl_d.tcnt = ctl_q.tcnt + 1'b1;
                end
                if (fall && (ctl_q.tcnt == TW'(TAIL_CLKS))) begin
                    ctl_d.st = ST_DONE;
                end
            end
            default: begin
                ctl_d.st = ctl_q.st;
            end
        endcase

        if (accept) begin
            ctl_d.st   = ST_WAIT;
            ctl_d.addr = '0;
            ctl_d.exh  = 1'b0;
            ctl_d.tcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_POR;
            ctl_q.addr  <= '0;
            ctl_q.exh   <= 1'b0;
            ctl_q.tcnt  <= '0;
            ctl_q.por   <= '0;
            ctl_q.oelow <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_w     = ctl_q.st;
    assign data_oe_o   = (ctl_q.st == ST_RUN) && !ctl_q.exh && !cs_n_i && oe_i;
    assign cascade_n_o = !ctl_q.exh;
    assign init_n_o    = !init_active;

endmodule

// File: rtl/cfg_stream_master_chk.sv
module cfg_stream_master_chk
    import cfg_stream_pkg::*;
#(
    parameter int INIT_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       oe_i,
    input logic       dclk_o,
    input logic       data_o,
    input logic       cascade_n_o,
    input logic       init_n_o,
    input cfg_state_e st
);

    localparam int CW = $clog2(INIT_CYCLES + 2);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (init_n_o) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CW'(INIT_CYCLES + 1)) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // R1
    por_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POR) |-> !dclk_o);

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> $stable(data_o));

    // R3
    casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade_n_o && oe_i) |=> !cascade_n_o);

    // R4
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |-> !dclk_o);

    // R5
    wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (cascade_n_o && !dclk_o));

    // R7
    init_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_n_o) |=> !init_n_o);

    // R7
    init_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt_q <= CW'(INIT_CYCLES));

endmodule

bind cfg_stream_master cfg_stream_master_chk #(.INIT_CYCLES(INIT_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_i       (oe_i),
    .dclk_o     (dclk_o),
    .data_o     (data_o),
    .cascade_n_o(cascade_n_o),
    .init_n_o   (init_n_o),
    .st         (state_w)
);

// File: tb/cfg_stream_master_bench.sv
module cfg_stream_master_bench;

    localparam int IMG_BITS    = 64;
    localparam int CLK_DIV     = 4;
    localparam int TAIL_CLKS   = 16;
    localparam int POR_CYCLES  = 40;
    localparam int OE_MIN_LOW  = 3;
    localparam int INIT_CYCLES = 8;
    localparam int AW          = $clog2(IMG_BITS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic          wr_bit_i = 1'b0;
    logic          oe_i = 1'b1;
    logic          cs_n_i = 1'b0;
    logic          start_cmd_i = 1'b0;
    logic          dclk_o, data_o, data_oe_o, cascade_n_o, init_n_o;

    int checks = 0;
    int errors = 0;
    int rise_n = 0;
    int cap_n  = 0;
    logic cap_bits [0:1023];
    logic prev_dclk = 1'b0;

    cfg_stream_master #(
        .IMG_BITS(IMG_BITS), .CLK_DIV(CLK_DIV), .TAIL_CLKS(TAIL_CLKS),
        .POR_CYCLES(POR_CYCLES), .OE_MIN_LOW(OE_MIN_LOW), .INIT_CYCLES(INIT_CYCLES)
    ) u_cfg_stream_master (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_bit_i(wr_bit_i), .oe_i(oe_i), .cs_n_i(cs_n_i), .start_cmd_i(start_cmd_i),
        .dclk_o(dclk_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .cascade_n_o(cascade_n_o), .init_n_o(init_n_o)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (dclk_o && !prev_dclk) begin
            rise_n++;
            if (data_oe_o) begin
                if (cap_n < 1024) cap_bits[cap_n] = data_o;
                cap_n++;
            end
        end
        prev_dclk = dclk_o;
    end

    function automatic logic pat(input int i);
        return ((i * 37 + 11) % 13) > 6;
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_casc_low(output int n);
        n = 0;
        while (cascade_n_o && n < 4000) begin
            step();
            n++;
        end
    endtask

    task automatic oe_reset();
        oe_i = 1'b0;
        repeat (OE_MIN_LOW) step();
        oe_i = 1'b1;
    endtask

    task automatic t_reset_state();
        chk("R1 dclk at reset", dclk_o, 0);
        chk("R1 data_oe at reset", data_oe_o, 0);
        chk("R3 cascade_n at reset", cascade_n_o, 1);
        chk("R7 init_n at reset", init_n_o, 1);
    endtask

    task automatic t_por();
        int n = 0;
        repeat (POR_CYCLES - 4) begin
            step();
            n++;
        end
        chk("R1 no clock during delay", rise_n, 0);
        chk("R1 no data drive during delay", data_oe_o, 0);
        while (rise_n == 0 && n < 1000) begin
            step();
            n++;
        end
        chk("R1 first edge after delay", (n >= POR_CYCLES && n <= POR_CYCLES + CLK_DIV) ? 1 : 0, 1);
    endtask

    task automatic t_stream();
        int n, bad, r0;
        wait_casc_low(n);
        chk("R3 bits before cascade", cap_n, IMG_BITS);
        bad = 0;
        for (int i = 0; i < IMG_BITS; i++) if (cap_bits[i] !== pat(i)) bad++;
        chk("R2 bit order mismatches", bad, 0);
        r0 = rise_n;
        repeat (5 * CLK_DIV) step();
        chk("R3 clock continues after cascade", (rise_n > r0) ? 1 : 0, 1);
        chk("R3 no data after cascade", cap_n, IMG_BITS);
        chk("R3 cascade_n held", cascade_n_o, 0);
    endtask

    task automatic t_tail();
        int r0 = rise_n;
        cs_n_i = 1'b1;
        #1;
        chk("R4 data released on deselect", data_oe_o, 0);
        repeat (30 * CLK_DIV) step();
        chk("R4 tail edge count", rise_n - r0, TAIL_CLKS);
        chk("R4 clock parked low", dclk_o, 0);
        r0 = rise_n;
        repeat (20) step();
        chk("R4 clock stays stopped", rise_n - r0, 0);
    endtask

    task automatic t_oe_reset();
        int n, c0, r0, bad;
        cs_n_i = 1'b0;
        r0 = rise_n;
        oe_reset();
        chk("R5 cascade released", cascade_n_o, 1);
        c0 = cap_n;
        n = 0;
        while (rise_n == r0 && n < 1000) begin
            step();
            n++;
        end
        chk("R5 restart without delay", (n <= CLK_DIV) ? 1 : 0, 1);
        while (cap_n - c0 < 20) step();
        oe_i = 1'b0;
        r0 = rise_n;
        for (int k = 0; k < OE_MIN_LOW - 1; k++) begin
            step();
            chk("R6 data released while paused", data_oe_o, 0);
        end
        chk("R6 clock frozen while paused", rise_n - r0, 0);
        oe_i = 1'b1;
        wait_casc_low(n);
        chk("R6 bit count after pause", cap_n - c0, IMG_BITS);
        bad = 0;
        for (int i = 0; i < IMG_BITS; i++) if (cap_bits[c0 + i] !== pat(i)) bad++;
        chk("R5 R6 restart order mismatches", bad, 0);
    endtask

    task automatic t_init();
        int lows = 0;
        start_cmd_i = 1'b1;
        for (int k = 0; k < 4 * INIT_CYCLES; k++) begin
            step();
            if (!init_n_o) lows++;
            start_cmd_i = (k == 2);
        end
        start_cmd_i = 1'b0;
        chk("R7 pulse length with retrigger", lows, INIT_CYCLES);
        lows = 0;
        start_cmd_i = 1'b1;
        for (int k = 0; k < 2 * INIT_CYCLES; k++) begin
            step();
            if (!init_n_o) lows++;
            start_cmd_i = 1'b0;
        end
        chk("R7 second pulse length", lows, INIT_CYCLES);
    endtask

    task automatic t_rewrite();
        int n, c0, bad;
        cs_n_i = 1'b1;
        repeat (30 * CLK_DIV) step();
        for (int i = 0; i < IMG_BITS; i++) begin
            wr_en_i = 1'b1;
            wr_addr_i = AW'(i);
            wr_bit_i = !pat(i);
            step();
        end
        wr_en_i = 1'b0;
        cs_n_i = 1'b0;
        oe_reset();
        c0 = cap_n;
        wait_casc_low(n);
        chk("R8 rewritten bit count", cap_n - c0, IMG_BITS);
        bad = 0;
        for (int i = 0; i < IMG_BITS; i++) if (cap_bits[c0 + i] !== !pat(i)) bad++;
        chk("R8 rewritten image mismatches", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL all: watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < IMG_BITS; i++) begin
            step();
            wr_en_i = 1'b1;
            wr_addr_i = AW'(i);
            wr_bit_i = pat(i);
        end
        step();
        wr_en_i = 1'b0;
        step();
        rst_n = 1'b1;
        t_reset_state();
        t_por();
        t_stream();
        t_tail();
        t_oe_reset();
        t_init();
        t_rewrite();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule